// File: doc/BRIEF.md
# Zero-Count Wear-Aware Page Placer

This block decides where the next page of write data goes, based on how much that data will stress the cells. Write data arrives one byte per beat. While the page streams in, the block adds up its programmed zero bits. In multi-level-cell mode it instead adds a weighted sum over the 2-bit cell levels. Separately, the block holds a small pool of free physical page slots. Each slot carries a valid bit and a running wear total, which is the sum of every zero count ever placed in that slot.

When the beat marked as last arrives, the block takes the valid slot with the least wear, so the heaviest remaining stress always lands on the least worn page. It reports that slot and the page's zero count one cycle later, adds the count to the slot's wear and withdraws the slot from the pool. Firmware returns slots to the pool through a load port. A load can either keep the slot's tracked wear or overwrite it with a known value. If the pool is empty when a page completes, the block flags an error and leaves the pool untouched.

Top module: `wear_page_placer`

## Requirements
- R1: After reset no assignment or error is reported, every slot is invalid with wear 0, and any partly counted page is discarded.
- R2: In single-level mode (`mlc_en`=0) a beat adds the number of 0 bits in `in_data`. Cycles with `in_valid` low add nothing and never end a page, whatever `in_last` and `in_data` hold. A page is all valid beats up to and including the one with `in_last`=1.
- R3: In multi-level mode (`mlc_en`=1, sampled per beat) a byte is four cells, bits [1:0], [3:2], [5:4] and [7:6]. Cell code 2'b11 adds 0, 2'b10 adds `W_SHALLOW` (default 1), 2'b01 adds `W_MID` (default 2) and 2'b00 adds `W_DEEP` (default 3).
- R4: A completing page is assigned to the valid slot with the smallest wear. On equal wear the lowest index wins.
- R5: The chosen slot's wear grows by the page's zero count and saturates at 2^`WEAR_W`-1 instead of wrapping.
- R6: An assigned slot becomes invalid and is not chosen again until it is loaded.
- R7: A load marks `load_slot` valid. With `load_set_wear`=1 its wear becomes `load_wear`; with 0 the tracked wear is kept. A load to the slot being assigned in the same cycle leaves it valid, with the wear after the increment (when kept).
- R8: For a completing page that finds a valid slot, `asg_valid` pulses high for exactly one cycle, one clock after the last beat, with `asg_slot` and `asg_zeros`.
- R9: For a completing page that finds no valid slot, `asg_error` pulses instead of `asg_valid`, `asg_zeros` still carries the count, and no slot changes.
- R10: The page zero count saturates at 2^`CNT_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data beat present |
| in_last | input | 1 | Beat closes the page |
| in_data | input | 8 | Write data byte |
| mlc_en | input | 1 | Weighted multi-level counting for this beat |
| load_valid | input | 1 | Return a slot to the pool |
| load_slot | input | $clog2(SLOTS) | Slot being returned |
| load_set_wear | input | 1 | Overwrite the slot's wear with load_wear |
| load_wear | input | WEAR_W | Wear value for an overwriting load |
| asg_valid | output | 1 | Assignment pulse |
| asg_error | output | 1 | Page completed with an empty pool |
| asg_slot | output | $clog2(SLOTS) | Assigned slot |
| asg_zeros | output | CNT_W | Zero count of the completed page |

## Verification
The bench builds the block with its defaults: 8 slots, 32-bit wear, a 16-bit page count and cell weights 3/2/1. With 32-bit wear, a load of a value close to 2^32-1 followed by one small page is enough to hit wear saturation. Saturation then shows at the ports as a change in which slot wins. The 16-bit count lets a page of about 5500 all-zero multi-level beats push the zero count past its ceiling within the cycle budget. With 8 slots, equal wear values can be set up that exercise the lowest-index tie rule.

// File: rtl/wpp_pkg.sv
package wpp_pkg;

    localparam int SLOTS_DEF  = 8;
    localparam int WEAR_W_DEF = 32;
    localparam int CNT_W_DEF  = 16;
    localparam int CELLS_PER_BYTE = 4;

    // 2-bit cell programming level; erased cells store no charge
    typedef enum logic [1:0] {
        LVL_DEEP    = 2'b00,
        LVL_MID     = 2'b01,
        LVL_SHALLOW = 2'b10,
        LVL_ERASED  = 2'b11
    } cell_lvl_e;

    typedef enum logic {
        DENS_SLC = 1'b0,
        DENS_MLC = 1'b1
    } density_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // largest contribution one byte can make in either mode
    function automatic int beat_limit(input int w_deep, input int w_mid, input int w_shallow);
        return imax(8, CELLS_PER_BYTE * imax(w_deep, imax(w_mid, w_shallow)));
    endfunction

    function automatic logic [3:0] slc_zeros(input logic [7:0] b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            if (!b[i]) n = n + 4'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/wpp_zero_counter.sv
module wpp_zero_counter
    import wpp_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int W_DEEP    = 3,
    parameter int W_MID     = 2,
    parameter int W_SHALLOW = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [7:0]       in_data,
    input  logic             mlc_en,
    output logic             page_done,
    output logic [CNT_W-1:0] page_zeros
);

    localparam int BEAT_MAX = beat_limit(W_DEEP, W_MID, W_SHALLOW);
    localparam int BEAT_W   = $clog2(BEAT_MAX + 1);

    logic [BEAT_W-1:0] cell_w [CELLS_PER_BYTE];
    logic [BEAT_W-1:0] mlc_sum;
    logic [BEAT_W-1:0] beat_w;
    logic [CNT_W-1:0]  acc_q;
    logic [CNT_W:0]    acc_sum;
    logic [CNT_W-1:0]  acc_sat;
    density_e          dens;

    generate
        for (genvar c = 0; c < CELLS_PER_BYTE; c++) begin : g_cell
            always_comb begin
                case (cell_lvl_e'(in_data[2*c +: 2]))
                    LVL_DEEP:    cell_w[c] = BEAT_W'(W_DEEP);
                    LVL_MID:     cell_w[c] = BEAT_W'(W_MID);
                    LVL_SHALLOW: cell_w[c] = BEAT_W'(W_SHALLOW);
                    default:     cell_w[c] = '0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        mlc_sum = '0;
        for (int c = 0; c < CELLS_PER_BYTE; c++) begin
            mlc_sum = mlc_sum + cell_w[c];
        end
    end

    assign dens    = density_e'(mlc_en);
    assign beat_w  = (dens == DENS_MLC) ? mlc_sum : BEAT_W'(slc_zeros(in_data));
    assign acc_sum = {1'b0, acc_q} + (CNT_W+1)'(beat_w);
    assign acc_sat = acc_sum[CNT_W] ? '1 : acc_sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (in_valid) begin
            acc_q <= in_last ? '0 : acc_sat;
        end
    end

    assign page_done  = in_valid & in_last;
    assign page_zeros = acc_sat;

    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_last |=> acc_q == '0);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_q));

    // R10
    acc_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_last |=> acc_q >= $past(acc_q));

endmodule

// File: rtl/wpp_slot_pool.sv
module wpp_slot_pool
    import wpp_pkg::*;
#(
    parameter int SLOTS  = SLOTS_DEF,
    parameter int WEAR_W = WEAR_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          upd_en,
    input  logic [IDX_W-1:0]              upd_idx,
    input  logic [CNT_W-1:0]              upd_add,
    input  logic                          load_en,
    input  logic [IDX_W-1:0]              load_idx,
    input  logic                          load_set,
    input  logic [WEAR_W-1:0]             load_wear,
    output logic [SLOTS-1:0]              slot_valid,
    output logic [SLOTS-1:0][WEAR_W-1:0]  slot_wear
);

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic              v_q;
            logic [WEAR_W-1:0] w_q;
            logic [WEAR_W:0]   w_sum;
            logic [WEAR_W-1:0] w_inc;
            logic              hit_upd;
            logic              hit_load;

            assign hit_upd  = upd_en  && (upd_idx  == IDX_W'(s));
            assign hit_load = load_en && (load_idx == IDX_W'(s));
            assign w_sum    = {1'b0, w_q} + (WEAR_W+1)'(upd_add);
            assign w_inc    = w_sum[WEAR_W] ? '1 : w_sum[WEAR_W-1:0];

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    w_q <= '0;
                end else begin
                    if (hit_upd) begin
                        v_q <= 1'b0;
                        w_q <= w_inc;
                    end
                    if (hit_load) begin
                        v_q <= 1'b1;
                        if (load_set) w_q <= load_wear;
                    end
                end
            end

            assign slot_valid[s] = v_q;
            assign slot_wear[s]  = w_q;
        end
    endgenerate

    // R6
    taken_clear_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !(load_en && load_idx == upd_idx) |=> !slot_valid[$past(upd_idx)]);

    // R5
    wear_rise_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && !(load_en && load_set && load_idx == upd_idx)
        |=> slot_wear[$past(upd_idx)] >= $past(slot_wear[upd_idx]));

    // R7
    load_mark_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> slot_valid[$past(load_idx)]);

    // R7
    load_set_chk: assert property (@(posedge clk) disable iff (rst)
        load_en && load_set |=> slot_wear[$past(load_idx)] == $past(load_wear));

endmodule

// File: rtl/wpp_min_select.sv
module wpp_min_select
    import wpp_pkg::*;
#(
    parameter int SLOTS  = SLOTS_DEF,
    parameter int WEAR_W = WEAR_W_DEF,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]              slot_valid,
    input  logic [SLOTS-1:0][WEAR_W-1:0]  slot_wear,
    output logic                          found,
    output logic [IDX_W-1:0]              sel_idx
);

    logic [WEAR_W-1:0] best;

    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        best    = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_valid[s] && (!found || slot_wear[s] < best)) begin
                found   = 1'b1;
                sel_idx = IDX_W'(s);
                best    = slot_wear[s];
            end
        end
    end

endmodule

// File: rtl/wear_page_placer.sv
module wear_page_placer
    import wpp_pkg::*;
#(
    parameter int SLOTS     = SLOTS_DEF,
    parameter int WEAR_W    = WEAR_W_DEF,
    parameter int CNT_W     = CNT_W_DEF,
    parameter int W_DEEP    = 3,
    parameter int W_MID     = 2,
    parameter int W_SHALLOW = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_last,
    input  logic [7:0]                 in_data,
    input  logic                       mlc_en,
    input  logic                       load_valid,
    input  logic [$clog2(SLOTS)-1:0]   load_slot,
    input  logic                       load_set_wear,
    input  logic [WEAR_W-1:0]          load_wear,
    output logic                       asg_valid,
    output logic                       asg_error,
    output logic [$clog2(SLOTS)-1:0]   asg_slot,
    output logic [CNT_W-1:0]           asg_zeros
);

    localparam int IDX_W = $clog2(SLOTS);

    typedef struct packed {
        logic             ok;
        logic             err;
        logic [IDX_W-1:0] slot;
        logic [CNT_W-1:0] zeros;
    } asg_t;

    logic                         page_done;
    logic [CNT_W-1:0]             page_zeros;
    logic [SLOTS-1:0]             slot_valid;
    logic [SLOTS-1:0][WEAR_W-1:0] slot_wear;
    logic                         found;
    logic [IDX_W-1:0]             sel_idx;
    logic                         upd_en;
    asg_t                         asg_d;
    asg_t                         asg_q;

    wpp_zero_counter #(
        .CNT_W(CNT_W), .W_DEEP(W_DEEP), .W_MID(W_MID), .W_SHALLOW(W_SHALLOW)
    ) u_count (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .mlc_en(mlc_en),
        .page_done(page_done), .page_zeros(page_zeros)
    );

    wpp_min_select #(
        .SLOTS(SLOTS), .WEAR_W(WEAR_W), .IDX_W(IDX_W)
    ) u_select (
        .slot_valid(slot_valid), .slot_wear(slot_wear),
        .found(found), .sel_idx(sel_idx)
    );

    assign upd_en = page_done && found;

    wpp_slot_pool #(
        .SLOTS(SLOTS), .WEAR_W(WEAR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_pool (
        .clk(clk), .rst(rst),
        .upd_en(upd_en), .upd_idx(sel_idx), .upd_add(page_zeros),
        .load_en(load_valid), .load_idx(load_slot), .load_set(load_set_wear),
        .load_wear(load_wear),
        .slot_valid(slot_valid), .slot_wear(slot_wear)
    );

    always_comb begin
        asg_d       = '0;
        asg_d.ok    = upd_en;
        asg_d.err   = page_done && !found;
        asg_d.slot  = sel_idx;
        asg_d.zeros = page_zeros;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asg_q <= '0;
        end else begin
            asg_q.ok  <= asg_d.ok;
            asg_q.err <= asg_d.err;
            if (page_done) begin
                asg_q.slot  <= asg_d.slot;
                asg_q.zeros <= asg_d.zeros;
            end
        end
    end

    assign asg_valid = asg_q.ok;
    assign asg_error = asg_q.err;
    assign asg_slot  = asg_q.slot;
    assign asg_zeros = asg_q.zeros;

    // R8
    asg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        page_done && found |=> asg_valid && !asg_error);

    // R9
    empty_err_chk: assert property (@(posedge clk) disable iff (rst)
        page_done && !found |=> asg_error && !asg_valid);

    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !page_done |=> !asg_valid && !asg_error);

    // R9
    empty_pool_chk: assert property (@(posedge clk) disable iff (rst)
        page_done && !found && !load_valid |=> $stable(slot_valid) && $stable(slot_wear));

    always @(posedge clk) begin
        if (!rst && found) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (slot_valid[j]) begin
                    // R4
                    min_pick_chk: assert (slot_wear[sel_idx] <= slot_wear[j]);
                    if (j < int'(sel_idx)) begin
                        // R4
                        tie_low_chk: assert (slot_wear[j] != slot_wear[sel_idx]);
                    end
                end
            end
        end
    end

endmodule

// File: tb/wear_page_placer_bench.sv
module wear_page_placer_bench;

    localparam int     SLOTS    = 8;
    localparam longint WEAR_MAX = 64'h0000_0000_FFFF_FFFF;
    localparam longint CNT_MAX  = 65535;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_last, mlc_en;
    logic [7:0]  in_data;
    logic        load_valid, load_set_wear;
    logic [2:0]  load_slot;
    logic [31:0] load_wear;
    logic        asg_valid, asg_error;
    logic [2:0]  asg_slot;
    logic [15:0] asg_zeros;

    always #4 clk = ~clk;

    wear_page_placer u_wear_page_placer (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .mlc_en(mlc_en),
        .load_valid(load_valid), .load_slot(load_slot), .load_set_wear(load_set_wear),
        .load_wear(load_wear),
        .asg_valid(asg_valid), .asg_error(asg_error), .asg_slot(asg_slot), .asg_zeros(asg_zeros)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    bit     finished = 1'b0;
    longint m_wear [SLOTS];
    bit     m_valid[SLOTS];
    int     last_pick;

    // {mlc, seed, step, beats}
    localparam logic [24:0] TBL [8] = '{
        {1'b0, 8'h00, 8'h00, 8'd3},
        {1'b0, 8'hFF, 8'h00, 8'd4},
        {1'b1, 8'h1B, 8'h25, 8'd6},
        {1'b0, 8'h5A, 8'h11, 8'd9},
        {1'b1, 8'h00, 8'h00, 8'd2},
        {1'b1, 8'hFF, 8'h01, 8'd5},
        {1'b0, 8'h80, 8'h07, 8'd1},
        {1'b1, 8'hE4, 8'h03, 8'd7}
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int beat_weight(input logic [7:0] d, input bit mlc);
        int n = 0;
        if (!mlc) begin
            for (int i = 0; i < 8; i++) if (!d[i]) n++;
        end else begin
            for (int c = 0; c < 4; c++) begin
                case (d[2*c +: 2])
                    2'b00:   n += 3;
                    2'b01:   n += 2;
                    2'b10:   n += 1;
                    default: n += 0;
                endcase
            end
        end
        return n;
    endfunction

    function automatic int model_pick();
        int p = -1;
        for (int s = 0; s < SLOTS; s++) begin
            if (m_valid[s] && (p < 0 || m_wear[s] < m_wear[p])) p = s;
        end
        return p;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00; mlc_en = 1'b0;
        load_valid = 1'b0; load_set_wear = 1'b0; load_slot = 3'd0; load_wear = 32'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            m_wear[s] = 0;
            m_valid[s] = 1'b0;
        end
    endtask

    task automatic load(input int slot, input bit set, input longint wear);
        load_valid = 1'b1; load_slot = slot[2:0]; load_set_wear = set; load_wear = wear[31:0];
        @(negedge clk);
        load_valid = 1'b0; load_set_wear = 1'b0;
        m_valid[slot] = 1'b1;
        if (set) m_wear[slot] = wear;
    endtask

    // outputs already reflect the edge that took the last beat
    task automatic expect_result(input string req, input longint total);
        longint z = (total > CNT_MAX) ? CNT_MAX : total;
        int p = model_pick();
        last_pick = p;
        chk(req, "page zero count", longint'(asg_zeros), z);
        if (p < 0) begin
            chk("R9", "error on empty pool", longint'(asg_error), 1);
            chk("R9", "no assignment on empty pool", longint'(asg_valid), 0);
        end else begin
            chk("R8", "assignment pulse", longint'(asg_valid), 1);
            chk("R4", "chosen slot", longint'(asg_slot), p);
            m_wear[p] = (m_wear[p] + z > WEAR_MAX) ? WEAR_MAX : m_wear[p] + z;
            m_valid[p] = 1'b0;
        end
        @(negedge clk);
        chk("R8", "single-cycle pulse", longint'(asg_valid | asg_error), 0);
    endtask

    task automatic send_page(input logic [7:0] seed, input logic [7:0] step, input int beats,
                             input bit mlc, input bit gaps, input string req);
        longint     total = 0;
        logic [7:0] d;
        for (int i = 0; i < beats; i++) begin
            d = seed + 8'(i) * step;
            total += beat_weight(d, mlc);
            in_valid = 1'b1; in_last = (i == beats - 1); in_data = d; mlc_en = mlc;
            @(negedge clk);
            if (gaps && i != beats - 1) begin
                in_valid = 1'b0; in_last = 1'b1; in_data = 8'h00; mlc_en = ~mlc;
                @(negedge clk);
                chk("R2", "idle cycle ended page", longint'(asg_valid | asg_error), 0);
            end
        end
        in_valid = 1'b0; in_last = 1'b0;
        expect_result(req, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R8 watchdog expired: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then an empty pool
        do_reset();
        chk("R1", "asg_valid after reset", longint'(asg_valid), 0);
        chk("R1", "asg_error after reset", longint'(asg_error), 0);
        send_page(8'h0F, 8'h00, 2, 1'b0, 1'b0, "R1");

        // R1: partial page is dropped by reset
        in_valid = 1'b1; in_last = 1'b0; in_data = 8'h00; mlc_en = 1'b0;
        repeat (2) @(negedge clk);
        do_reset();
        load(0, 1'b0, 0);
        send_page(8'hFF, 8'h00, 2, 1'b0, 1'b0, "R1");

        // table walk: R2/R3 counts, R4 minimum with tie at wear 10
        do_reset();
        begin
            longint init_w [8] = '{40, 10, 30, 10, 50, 20, 60, 70};
            for (int s = 0; s < SLOTS; s++) load(s, 1'b1, init_w[s]);
        end
        for (int i = 0; i < 8; i++) begin
            send_page(TBL[i][23:16], TBL[i][15:8], int'(TBL[i][7:0]), TBL[i][24], 1'b0,
                      TBL[i][24] ? "R3" : "R2");
            if (i % 2 == 0 && last_pick >= 0) load(last_pick, 1'b0, 0);
        end

        // R2: idle cycles with last high inside a page
        send_page(8'h3C, 8'h11, 4, 1'b0, 1'b1, "R2");
        send_page(8'h93, 8'h2D, 3, 1'b1, 1'b1, "R3");

        // R6: taken slot is skipped even with equal wear
        do_reset();
        load(1, 1'b1, 0);
        load(4, 1'b1, 0);
        send_page(8'hFF, 8'h00, 2, 1'b0, 1'b0, "R4");
        chk("R4", "tie goes to lowest index", longint'(last_pick), 1);
        send_page(8'hFF, 8'h00, 1, 1'b0, 1'b0, "R6");
        chk("R6", "assigned slot not reused", longint'(last_pick), 4);
        send_page(8'h00, 8'h00, 1, 1'b0, 1'b0, "R9");
        load(1, 1'b0, 0);
        send_page(8'h01, 8'h00, 1, 1'b0, 1'b0, "R7");
        chk("R7", "kept-wear reload reusable", longint'(last_pick), 1);

        // R7: load collides with assignment of the same slot
        do_reset();
        load(5, 1'b1, 100);
        load(2, 1'b1, 200);
        in_valid = 1'b1; in_last = 1'b0; in_data = 8'hF0; mlc_en = 1'b0;
        @(negedge clk);
        in_last = 1'b1;
        load_valid = 1'b1; load_slot = 3'd5; load_set_wear = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; load_valid = 1'b0;
        chk("R7", "collision slot", longint'(asg_slot), 5);
        chk("R7", "collision zeros", longint'(asg_zeros), 8);
        m_wear[5] = 108;
        @(negedge clk);
        send_page(8'hAA, 8'h00, 1, 1'b0, 1'b0, "R7");
        chk("R7", "slot stays valid after collision", longint'(last_pick), 5);

        // R5: wear saturation decides the next winner
        do_reset();
        load(0, 1'b1, 64'hFFFF_FFF0);
        load(1, 1'b1, 64'hFFFF_FFFE);
        send_page(8'h00, 8'h00, 4, 1'b0, 1'b0, "R5");
        load(0, 1'b0, 0);
        send_page(8'hFE, 8'h00, 1, 1'b0, 1'b0, "R5");
        chk("R5", "saturated slot loses", longint'(last_pick), 1);

        // R10: page count ceiling
        do_reset();
        load(3, 1'b1, 0);
        send_page(8'h00, 8'h00, 5500, 1'b1, 1'b0, "R10");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule